// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits on the inbound side of a PCI-style host bridge. A bus master presents a 32-bit bus address, and the block checks it against a small set of programmable address windows. Each window has a base register, a size mask and a translated base. A window in direct mode turns the address into a physical memory address: the translated base plus the offset inside the window. A window in scatter-gather mode instead produces the physical address of the page-table entry (PTE) that a separate lookaside unit must fetch. The highest-numbered window always works as scatter-gather. When no enabled window matches, the block raises a miss so that the transaction can be rejected.

Software programs the windows through a simple register port. Writes take effect at a clock edge, and reads are combinational. Each translation is registered once. A small state machine holds the class of the result for the cycle after the request. It has four states. In `ST_IDLE` there is no response. In `ST_DIRECT` a direct translation is valid, in `ST_SCATTER` a PTE address is valid, and in `ST_MISS` the address matched nothing. On every clock edge the next state comes from the current request. With no `req_valid` the machine goes to `ST_IDLE`. With a request and no match it goes to `ST_MISS`. With a match in a scatter-gather window it goes to `ST_SCATTER`, and with any other match it goes to `ST_DIRECT`. Any state can move to any other state in one cycle.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset all window registers read 0, `rsp_valid` is low, and a request then reports a miss.
- R2: `cfg_addr[3:2]` selects the window and `cfg_addr[1:0]` selects the register: 0 = base, 1 = mask, 2 = translated base, 3 = reserved. The base register keeps bits 31:20 and bits 1:0, the mask keeps bits 31:20 only, the translated base keeps all 32 bits, and the reserved slot reads 0.
- R3: An address hits a window when base bit 0 (enable) is 1 and the address bits 31:20 that are clear in the mask equal the same bits of the base.
- R4: On a direct hit, `rsp_addr` = translated base + (address AND (mask OR 0x000F_FFFF)), and `rsp_sg` = 0.
- R5: When base bit 1 is 1, a hit is scatter-gather. In that case `rsp_sg` = 1 and `rsp_addr` = translated base + (offset / PAGE_BYTES) * 8, with a default PAGE_BYTES of 8192.
- R6: Window 3 always behaves as scatter-gather, whatever the value of its base bit 1.
- R7: Writing 0 to a window's base register disables that window, and an address it used to match then falls through to the next window or misses.
- R8: When several enabled windows match, the lowest-numbered one wins, and its number appears on `rsp_win`.
- R9: A request that hits no enabled window gives `rsp_miss` = 1, `rsp_sg` = 0 and `rsp_addr` = 0.
- R10: The response appears exactly one cycle after `req_valid`, and `rsp_valid` is low in any cycle that follows a cycle without a request. Back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Window index (bits 3:2) and register select (bits 1:0) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data of the addressed register |
| req_valid | input | 1 | Inbound address valid |
| req_addr | input | 32 | Inbound bus address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_sg | output | 1 | Result is a PTE address (scatter-gather) |
| rsp_win | output | 2 | Number of the winning window |
| rsp_addr | output | 32 | Physical address or PTE address; 0 on a miss |

## Verification
Every translation result is due at the first clock edge after the edge that captured `req_valid`. The bench drives a request on a falling edge and removes it on the next falling edge. It compares `rsp_*` at that second falling edge, which lies half a period after the register has loaded. In back-to-back runs, each result is sampled on the falling edge where the following address is being driven. Register read-back has no latency, so it is sampled a short delay after the address changes on a falling edge. Register writes are made at least one full cycle before any request that depends on them.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_XBASE = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIRECT  = 2'd1,
        ST_SCATTER = 2'd2,
        ST_MISS    = 2'd3
    } xl_state_e;
endpackage

// File: rtl/dwx_regs.sv
module dwx_regs
    import dwx_pkg::*;
#(
    parameter int NWIN      = 4,
    parameter int AW        = 32,
    parameter int GRAN_BITS = 20,
    localparam int IDXW     = $clog2(NWIN),
    localparam int CAW      = IDXW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CAW-1:0] addr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic [AW-1:0] base_o  [NWIN],
    output logic [AW-1:0] mask_o  [NWIN],
    output logic [AW-1:0] xbase_o [NWIN]
);
    localparam logic [AW-1:0] HI_KEEP   = {{(AW-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};
    localparam logic [AW-1:0] BASE_KEEP = HI_KEEP | AW'(3);

    logic [IDXW-1:0] widx;
    reg_sel_e        rsel;

    assign widx = addr[CAW-1:2];
    assign rsel = reg_sel_e'(addr[1:0]);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[w]  <= '0;
                mask_o[w]  <= '0;
                xbase_o[w] <= '0;
            end else if (we && widx == IDXW'(w)) begin
                unique case (rsel)
                    SEL_BASE:  base_o[w]  <= wdata & BASE_KEEP;
                    SEL_MASK:  mask_o[w]  <= wdata & HI_KEEP;
                    SEL_XBASE: xbase_o[w] <= wdata;
                    SEL_RSVD:  ;
                endcase
            end
        end

        // R2
        mask_gran_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_o[w] & ~HI_KEEP) == '0);
    end

    always_comb begin
        unique case (rsel)
            SEL_BASE:  rdata = base_o[widx];
            SEL_MASK:  rdata = mask_o[widx];
            SEL_XBASE: rdata = xbase_o[widx];
            SEL_RSVD:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dwx_win_cmp.sv
module dwx_win_cmp #(
    parameter int AW        = 32,
    parameter int GRAN_BITS = 20,
    parameter bit FORCE_SG  = 1'b0
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic          hit,
    output logic          sg,
    output logic [AW-1:0] offset
);
    localparam logic [AW-1:0] HI_KEEP = {{(AW-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

    logic [AW-1:0] cmp_bits;

    assign cmp_bits = HI_KEEP & ~mask;
    assign hit      = base[0] && (((addr ^ base) & cmp_bits) == '0);
    assign offset   = addr & ~cmp_bits;
    assign sg       = FORCE_SG ? 1'b1 : base[1];
endmodule

// File: rtl/dwx_prio.sv
module dwx_prio #(
    parameter int N   = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end

    // R8
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate
    import dwx_pkg::*;
#(
    parameter int NWIN       = 4,
    parameter int AW         = 32,
    parameter int GRAN_BITS  = 20,
    parameter int PAGE_BYTES = 8192,
    parameter int PTE_BYTES  = 8,
    localparam int IDXW      = $clog2(NWIN),
    localparam int CAW       = IDXW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CAW-1:0]  cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    output logic [AW-1:0]   cfg_rdata,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            rsp_valid,
    output logic            rsp_miss,
    output logic            rsp_sg,
    output logic [IDXW-1:0] rsp_win,
    output logic [AW-1:0]   rsp_addr
);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int PTE_SHIFT  = $clog2(PTE_BYTES);

    logic [AW-1:0]   base_r  [NWIN];
    logic [AW-1:0]   mask_r  [NWIN];
    logic [AW-1:0]   xbase_r [NWIN];
    logic [NWIN-1:0] win_hit;
    logic [NWIN-1:0] win_sg;
    logic [AW-1:0]   win_off [NWIN];
    logic [NWIN-1:0] grant;
    logic [IDXW-1:0] win_idx;
    logic            any_hit;
    logic            sel_sg;
    logic [AW-1:0]   sel_off;
    logic [AW-1:0]   sel_xbase;
    logic [AW-1:0]   xl_addr;

    xl_state_e       state_q, state_d;
    logic [IDXW-1:0] win_q;
    logic [AW-1:0]   addr_q;

    dwx_regs #(.NWIN(NWIN), .AW(AW), .GRAN_BITS(GRAN_BITS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .base_o  (base_r),
        .mask_o  (mask_r),
        .xbase_o (xbase_r)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        dwx_win_cmp #(
            .AW        (AW),
            .GRAN_BITS (GRAN_BITS),
            .FORCE_SG  (w == NWIN - 1)
        ) u_cmp (
            .addr   (req_addr),
            .base   (base_r[w]),
            .mask   (mask_r[w]),
            .hit    (win_hit[w]),
            .sg     (win_sg[w]),
            .offset (win_off[w])
        );
    end

    dwx_prio #(.N(NWIN)) u_prio (
        .req   (win_hit),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_hit)
    );

    assign sel_sg    = win_sg[win_idx];
    assign sel_off   = win_off[win_idx];
    assign sel_xbase = xbase_r[win_idx];
    assign xl_addr   = sel_sg ? sel_xbase + ((sel_off >> PAGE_SHIFT) << PTE_SHIFT)
                              : sel_xbase + sel_off;

    // next-state decision
    always_comb begin
        if (!req_valid)      state_d = ST_IDLE;
        else if (!any_hit)   state_d = ST_MISS;
        else if (sel_sg)     state_d = ST_SCATTER;
        else                 state_d = ST_DIRECT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            addr_q <= '0;
        end else if (req_valid) begin
            win_q  <= win_idx;
            addr_q <= any_hit ? xl_addr : '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_miss  = 1'b0;
        rsp_sg    = 1'b0;
        rsp_win   = '0;
        rsp_addr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DIRECT: begin
                rsp_valid = 1'b1;
                rsp_win   = win_q;
                rsp_addr  = addr_q;
            end
            ST_SCATTER: begin
                rsp_valid = 1'b1;
                rsp_sg    = 1'b1;
                rsp_win   = win_q;
                rsp_addr  = addr_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
        endcase
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9
    miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit == '0) |=> (rsp_miss && !rsp_sg && rsp_addr == '0));
    // R6
    last_win_sg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit == NWIN'(1) << (NWIN - 1)) |=> rsp_sg);
    // R8
    lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit[0]) |=> (rsp_win == '0 && !rsp_miss));
endmodule

// File: tb/tb_dma_win_xlate.sv
module tb_dma_win_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_miss, rsp_sg;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dma_win_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_sg(rsp_sg), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int win, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'((win << 2) | sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int win, input int sel, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = 4'((win << 2) | sel);
        #1 check(tag, cfg_rdata, exp);
    endtask

    // one request, then compare the registered response
    task automatic xl_chk(input string tag, input logic [31:0] a, input logic miss,
                          input logic sg, input logic [1:0] win, input logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " miss"},  32'(rsp_miss), 32'(miss));
        check({tag, " sg"},    32'(rsp_sg), 32'(sg));
        if (!miss) check({tag, " win"}, 32'(rsp_win), 32'(win));
        check({tag, " addr"},  rsp_addr, pa);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        rd_chk("R1 base0 reset", 0, 0, 32'h0);
        rd_chk("R1 xbase2 reset", 2, 2, 32'h0);
        xl_chk("R1 request after reset", 32'h8000_0000, 1'b1, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_regs();
        wr(3, 0, 32'hFFFF_FFFF);
        wr(3, 1, 32'hFFFF_FFFF);
        wr(3, 2, 32'h1234_5677);
        rd_chk("R2 base keeps 31:20 and 1:0", 3, 0, 32'hFFF0_0003);
        rd_chk("R2 mask keeps 31:20", 3, 1, 32'hFFF0_0000);
        rd_chk("R2 xbase keeps all", 3, 2, 32'h1234_5677);
        rd_chk("R2 reserved reads 0", 3, 3, 32'h0);
    endtask

    task automatic t_program();
        wr(0, 0, 32'h0080_0003); wr(0, 1, 32'h007F_FFFF); wr(0, 2, 32'h1000_0000);
        wr(1, 0, 32'h8000_0001); wr(1, 1, 32'h3FFF_FFFF); wr(1, 2, 32'h0000_0000);
        wr(2, 0, 32'hC000_0003); wr(2, 1, 32'h3FFF_FFFF); wr(2, 2, 32'h2000_0000);
        wr(3, 0, 32'h0100_0001); wr(3, 1, 32'h000F_FFFF); wr(3, 2, 32'h3000_0000);
    endtask

    task automatic t_direct();
        xl_chk("R4 direct window 1", 32'h8123_4567, 1'b0, 1'b0, 2'd1, 32'h0123_4567);
        xl_chk("R3 top of window 1", 32'hBFFF_FFFC, 1'b0, 1'b0, 2'd1, 32'h3FFF_FFFC);
    endtask

    task automatic t_sg();
        xl_chk("R5 sg window 0", 32'h0085_6000, 1'b0, 1'b1, 2'd0, 32'h1000_0158);
        xl_chk("R5 sg window 2", 32'hC000_4000, 1'b0, 1'b1, 2'd2, 32'h2000_0010);
    endtask

    task automatic t_forced();
        xl_chk("R6 window 3 forced sg", 32'h0100_E000, 1'b0, 1'b1, 2'd3, 32'h3000_0038);
    endtask

    task automatic t_miss();
        xl_chk("R9 miss", 32'h4000_0000, 1'b1, 1'b0, 2'd0, 32'h0);
        xl_chk("R3 just below window 0", 32'h007F_FFFC, 1'b1, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_prio_disable();
        wr(2, 0, 32'h8000_0003);
        xl_chk("R8 lowest window wins", 32'h8000_2000, 1'b0, 1'b0, 2'd1, 32'h0000_2000);
        wr(1, 0, 32'h0);
        xl_chk("R7 disabled falls through", 32'h8000_2000, 1'b0, 1'b1, 2'd2, 32'h2000_0008);
        wr(2, 0, 32'h0);
        xl_chk("R7 both disabled miss", 32'h8000_2000, 1'b1, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_timing();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0085_6000;
        @(negedge clk);
        req_addr = 32'h0100_E000;
        check("R10 b2b first addr", rsp_addr, 32'h1000_0158);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 b2b second addr", rsp_addr, 32'h3000_0038);
        check("R10 b2b second win", 32'(rsp_win), 32'd3);
        @(negedge clk);
        check("R10 idle after request", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_program();
        t_direct();
        t_sg();
        t_forced();
        t_miss();
        t_timing();
        t_prio_disable();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule